// File: doc/BRIEF.md
# Order-Based Ownership Conflict Resolver

This block sits in each processor's coherence path. It decides how to answer a read-to-own request that another processor sends for a line this processor holds during a multi-location update. While a local update attempt is open, the block keeps one bit for every bus id. The bit says whether that peer is known to be later in the global update order. The bits are filled from the order numbers that peers broadcast when they begin their own attempts.

When a read-to-own arrives from a peer that is not known to be later, the block gives up the line and aborts the local attempt. When it arrives from a later peer, the block protects its own progress. Under the refuse policy it sends a refusal code that makes the requester abort. Under the reclaim policy it hands the line over and at once issues its own read-to-own for the same address. The requester then applies the same rule, yields the line and aborts. When no local attempt is open, every read-to-own is answered with data.

Top module: `own_conflict_resolver`

## Requirements
- R1: With no local attempt open, a read-to-own is answered with data (kind code 1), with no abort and no reclaim request.
- R2: While an attempt is open, a broadcast from another bus id marks that peer later when its order number is greater than the local one. When the two order numbers are equal, the peer is marked later only if its bus id is greater than the local id. Otherwise the peer is marked earlier.
- R3: While an attempt is open, a read-to-own from a peer not marked later is answered with data. It also raises the abort output for exactly one cycle and closes the attempt.
- R4: In refuse mode (mode input 0), a read-to-own from a later peer is answered with refusal (kind code 2), with no abort.
- R5: In reclaim mode (mode input 1), a read-to-own from a later peer is answered with data. In the same cycle the block raises its own read-to-own request carrying the same line address, with no abort.
- R6: All peer marks are cleared, and the attempt closes, when the local attempt ends or aborts. Broadcasts received while no attempt is open leave no mark.
- R7: Each response appears on the output exactly one clock after its request, with kind code 0 when no response is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| self_id | input | ID_W | bus id of this processor |
| mode_reclaim | input | 1 | 0 refuse later peers, 1 reclaim after supplying |
| upd_start | input | 1 | local update attempt begins |
| upd_order | input | ORD_W | local order number, taken with upd_start |
| upd_end | input | 1 | local update attempt completes |
| bc_valid | input | 1 | peer order broadcast present |
| bc_id | input | ID_W | bus id of broadcasting peer |
| bc_order | input | ORD_W | order number broadcast by the peer |
| rto_valid | input | 1 | incoming read-to-own for a held line |
| rto_id | input | ID_W | bus id of the requester |
| rto_addr | input | ADDR_W | line address requested |
| resp_valid | output | 1 | response present |
| resp_kind | output | 2 | 0 none, 1 data, 2 refusal |
| abort_pulse | output | 1 | local attempt aborted, one cycle |
| reclaim_valid | output | 1 | own read-to-own issued |
| reclaim_addr | output | ADDR_W | line address being reclaimed |

## Verification
Read-to-own requests are applied from requesters in every ordering relation: one with strictly greater order, one with strictly smaller order, and two that tie on order number and differ only in bus id. One requester never broadcast at all. Together these separate the comparison, the tie rule and the default of yielding. The same later requester is tried under both policies, and again after the attempt has aborted or ended, which shows that the marks are really cleared. A broadcast sent while no attempt is open, followed by a new attempt, shows that such traffic is ignored.

// File: rtl/ocr_pkg.sv
package ocr_pkg;
    typedef enum logic [1:0] {
        RESP_NONE = 2'd0,
        RESP_DATA = 2'd1,
        RESP_NAK  = 2'd2
    } resp_e;
endpackage

// File: rtl/ocr_order_track.sv
module ocr_order_track #(
    parameter int NUM_IDS = 16,
    parameter int ORD_W   = 16,
    localparam int ID_W   = $clog2(NUM_IDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ID_W-1:0]    self_id,
    input  logic               start_i,
    input  logic [ORD_W-1:0]   start_order_i,
    input  logic               clr_i,
    input  logic               bc_valid,
    input  logic [ID_W-1:0]    bc_id,
    input  logic [ORD_W-1:0]   bc_order,
    output logic               active_o,
    output logic [NUM_IDS-1:0] later_o
);
    typedef struct packed {
        logic               active;
        logic [ORD_W-1:0]   order;
        logic [NUM_IDS-1:0] later;
    } trk_t;

    trk_t st_d, st_q;
    logic peer_later;

    always_comb begin
        peer_later = (bc_order > st_q.order) ||
                     ((bc_order == st_q.order) && (bc_id > self_id));
        st_d = st_q;
        if (clr_i) begin
            st_d.active = 1'b0;
            st_d.later  = '0;
        end else if (!st_q.active) begin
            if (start_i) begin
                st_d.active = 1'b1;
                st_d.order  = start_order_i;
                st_d.later  = '0;
            end
        end else if (bc_valid && (bc_id != self_id)) begin
            st_d.later[bc_id] = peer_later;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o = st_q.active;
    assign later_o  = st_q.later;

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!active_o && later_o == '0));
    p_idle_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o |-> later_o == '0);
    p_tie_lower_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !clr_i && bc_valid && bc_order == st_q.order && bc_id < self_id)
        |=> !later_o[$past(bc_id)]);
endmodule

// File: rtl/ocr_snoop_decide.sv
module ocr_snoop_decide
    import ocr_pkg::*;
#(
    parameter int NUM_IDS = 16,
    parameter int ADDR_W  = 40,
    localparam int ID_W   = $clog2(NUM_IDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_reclaim,
    input  logic               active_i,
    input  logic [NUM_IDS-1:0] later_i,
    input  logic               rto_valid,
    input  logic [ID_W-1:0]    rto_id,
    input  logic [ADDR_W-1:0]  rto_addr,
    output logic               abort_now_o,
    output logic               resp_valid,
    output resp_e              resp_kind,
    output logic               abort_pulse,
    output logic               reclaim_valid,
    output logic [ADDR_W-1:0]  reclaim_addr
);
    typedef struct packed {
        logic              rv;
        resp_e             kind;
        logic              abort;
        logic              grab;
        logic [ADDR_W-1:0] addr;
    } dec_t;

    dec_t dc_d, dc_q;
    logic req_later;

    always_comb begin
        req_later   = later_i[rto_id];
        abort_now_o = 1'b0;
        dc_d        = dc_q;
        dc_d.rv     = rto_valid;
        dc_d.kind   = RESP_NONE;
        dc_d.abort  = 1'b0;
        dc_d.grab   = 1'b0;
        if (rto_valid) begin
            if (!active_i) begin
                dc_d.kind = RESP_DATA;
            end else if (req_later) begin
                if (mode_reclaim) begin
                    dc_d.kind = RESP_DATA;
                    dc_d.grab = 1'b1;
                    dc_d.addr = rto_addr;
                end else begin
                    dc_d.kind = RESP_NAK;
                end
            end else begin
                dc_d.kind   = RESP_DATA;
                dc_d.abort  = 1'b1;
                abort_now_o = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dc_q <= '0;
        else        dc_q <= dc_d;
    end

    assign resp_valid    = dc_q.rv;
    assign resp_kind     = dc_q.kind;
    assign abort_pulse   = dc_q.abort;
    assign reclaim_valid = dc_q.grab;
    assign reclaim_addr  = dc_q.addr;

    p_resp_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rto_valid |=> (resp_valid && resp_kind != RESP_NONE));
    p_abort_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |=> !abort_pulse);
    p_nak_no_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_kind == RESP_NAK) |-> (!abort_pulse && !reclaim_valid));
    p_grab_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reclaim_valid |-> (resp_kind == RESP_DATA && !abort_pulse));
    p_idle_plain_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rto_valid && !active_i) |=> (!abort_pulse && !reclaim_valid));
endmodule

// File: rtl/own_conflict_resolver.sv
module own_conflict_resolver
    import ocr_pkg::*;
#(
    parameter int NUM_IDS = 16,
    parameter int ORD_W   = 16,
    parameter int ADDR_W  = 40,
    localparam int ID_W   = $clog2(NUM_IDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   self_id,
    input  logic              mode_reclaim,
    input  logic              upd_start,
    input  logic [ORD_W-1:0]  upd_order,
    input  logic              upd_end,
    input  logic              bc_valid,
    input  logic [ID_W-1:0]   bc_id,
    input  logic [ORD_W-1:0]  bc_order,
    input  logic              rto_valid,
    input  logic [ID_W-1:0]   rto_id,
    input  logic [ADDR_W-1:0] rto_addr,
    output logic              resp_valid,
    output logic [1:0]        resp_kind,
    output logic              abort_pulse,
    output logic              reclaim_valid,
    output logic [ADDR_W-1:0] reclaim_addr
);
    logic               active_w;
    logic [NUM_IDS-1:0] later_w;
    logic               abort_now_w;
    resp_e              kind_w;

    ocr_order_track #(.NUM_IDS(NUM_IDS), .ORD_W(ORD_W)) u_track (
        .clk           (clk),
        .rst_n         (rst_n),
        .self_id       (self_id),
        .start_i       (upd_start),
        .start_order_i (upd_order),
        .clr_i         (upd_end | abort_now_w),
        .bc_valid      (bc_valid),
        .bc_id         (bc_id),
        .bc_order      (bc_order),
        .active_o      (active_w),
        .later_o       (later_w)
    );

    ocr_snoop_decide #(.NUM_IDS(NUM_IDS), .ADDR_W(ADDR_W)) u_decide (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_reclaim  (mode_reclaim),
        .active_i      (active_w),
        .later_i       (later_w),
        .rto_valid     (rto_valid),
        .rto_id        (rto_id),
        .rto_addr      (rto_addr),
        .abort_now_o   (abort_now_w),
        .resp_valid    (resp_valid),
        .resp_kind     (kind_w),
        .abort_pulse   (abort_pulse),
        .reclaim_valid (reclaim_valid),
        .reclaim_addr  (reclaim_addr)
    );

    assign resp_kind = kind_w;
endmodule

// File: tb/sim_own_conflict_resolver.sv
module sim_own_conflict_resolver;
    localparam int NUM_IDS = 16;
    localparam int ORD_W   = 16;
    localparam int ADDR_W  = 40;
    localparam int ID_W    = $clog2(NUM_IDS);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ID_W-1:0]   self_id = 4'd5;
    logic              mode_reclaim = 1'b0;
    logic              upd_start = 1'b0;
    logic [ORD_W-1:0]  upd_order = '0;
    logic              upd_end = 1'b0;
    logic              bc_valid = 1'b0;
    logic [ID_W-1:0]   bc_id = '0;
    logic [ORD_W-1:0]  bc_order = '0;
    logic              rto_valid = 1'b0;
    logic [ID_W-1:0]   rto_id = '0;
    logic [ADDR_W-1:0] rto_addr = '0;
    logic              resp_valid;
    logic [1:0]        resp_kind;
    logic              abort_pulse;
    logic              reclaim_valid;
    logic [ADDR_W-1:0] reclaim_addr;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    own_conflict_resolver #(.NUM_IDS(NUM_IDS), .ORD_W(ORD_W), .ADDR_W(ADDR_W)) u0 (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic start_upd(input logic [ORD_W-1:0] ord);
        upd_start = 1'b1; upd_order = ord;
        tick();
        upd_start = 1'b0;
    endtask

    task automatic end_upd();
        upd_end = 1'b1;
        tick();
        upd_end = 1'b0;
    endtask

    task automatic bcast(input logic [ID_W-1:0] id, input logic [ORD_W-1:0] ord);
        bc_valid = 1'b1; bc_id = id; bc_order = ord;
        tick();
        bc_valid = 1'b0;
    endtask

    task automatic rto_expect(input string req, input logic [ID_W-1:0] id,
                              input logic [ADDR_W-1:0] addr, input logic [1:0] kind,
                              input logic ab, input logic gr);
        rto_valid = 1'b1; rto_id = id; rto_addr = addr;
        tick();
        rto_valid = 1'b0;
        chk({req, " resp_valid"}, 64'(resp_valid), 64'd1);
        chk({req, " kind"}, 64'(resp_kind), 64'(kind));
        chk({req, " abort"}, 64'(abort_pulse), 64'(ab));
        chk({req, " reclaim"}, 64'(reclaim_valid), 64'(gr));
        if (gr) chk({req, " reclaim_addr"}, 64'(reclaim_addr), 64'(addr));
        tick();
        chk({req, " one-cycle R7"}, 64'({resp_valid, abort_pulse, reclaim_valid}), 64'd0);
    endtask

    task automatic t_reset();
        chk("reset R7 resp", 64'(resp_valid), 64'd0);
        chk("reset R7 kind", 64'(resp_kind), 64'd0);
        chk("reset R3 abort", 64'(abort_pulse), 64'd0);
    endtask

    task automatic t_idle();
        rto_expect("R1 idle", 4'd3, 40'h100, 2'd1, 1'b0, 1'b0);
    endtask

    task automatic t_refuse();
        mode_reclaim = 1'b0;
        start_upd(16'd100);
        bcast(4'd7, 16'd120);
        bcast(4'd2, 16'd80);
        bcast(4'd9, 16'd100);
        bcast(4'd3, 16'd100);
        rto_expect("R4 later refuse", 4'd7, 40'h200, 2'd2, 1'b0, 1'b0);
        rto_expect("R2 tie higher id refuse", 4'd9, 40'h210, 2'd2, 1'b0, 1'b0);
        rto_expect("R2 tie lower id yields R3", 4'd3, 40'h220, 2'd1, 1'b1, 1'b0);
        rto_expect("R6 after abort cleared", 4'd7, 40'h230, 2'd1, 1'b0, 1'b0);
    endtask

    task automatic t_earlier_and_unknown();
        mode_reclaim = 1'b0;
        start_upd(16'd100);
        bcast(4'd2, 16'd80);
        rto_expect("R2 earlier yields R3", 4'd2, 40'h300, 2'd1, 1'b1, 1'b0);
        start_upd(16'd40);
        rto_expect("R3 unknown peer yields", 4'd11, 40'h310, 2'd1, 1'b1, 1'b0);
    endtask

    task automatic t_reclaim();
        mode_reclaim = 1'b1;
        start_upd(16'd50);
        bcast(4'd7, 16'd60);
        rto_expect("R5 reclaim", 4'd7, 40'hAB_CDEF_0123, 2'd1, 1'b0, 1'b1);
        end_upd();
        rto_expect("R6 after end", 4'd7, 40'h400, 2'd1, 1'b0, 1'b0);
    endtask

    task automatic t_idle_bcast();
        mode_reclaim = 1'b0;
        bcast(4'd8, 16'd999);
        start_upd(16'd10);
        rto_expect("R6 idle broadcast ignored", 4'd8, 40'h500, 2'd1, 1'b1, 1'b0);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        #10 rst_n = 1'b1;
        tick();
        t_idle();
        t_refuse();
        t_earlier_and_unknown();
        t_reclaim();
        t_idle_bcast();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule